// File: doc/BRIEF.md
# Delay-Programmable C/A Spreading Code Replica Generator

This block produces several replicas of a GPS coarse/acquisition spreading code side by side. Each replica has its own satellite and its own integer chip delay. Two shared 10-stage maximal-length shift registers (call them G1 and G2) advance once per chip. Each replica picks a delayed version of each sequence by ANDing the register state with a loaded 10-bit mask and taking the parity of the result. The two parity bits are XORed to form the code bit. A mask pair therefore carries both the code phase and the satellite identity. Computing the masks is the caller's job.

Chip instants come from a modulo-1915 phase accumulator that adds 341 on every sample clock. This places exactly 1023 chips in 5745 samples. The accumulator's start value sets a common sub-chip delay of `fraction * 1915`. A start pulse captures the masks and the start value, seeds both registers with all ones and enters the running state. After every 1023rd chip the registers are reseeded, which keeps the replicas locked to the 1 ms code period.

The controller has two states. ST_IDLE is entered on reset, and in it the outputs are silent. ST_RUN is where code is produced. There are three transitions: reset to ST_IDLE; ST_IDLE to ST_RUN on `start_i`; and ST_RUN to ST_RUN (restart) on `start_i`, which reloads everything.

Top module: `ca_code_gen`

## Requirements
- R1: After reset and until the first start, `busy_o` is 0, `code_o` is all zeros and `chip_tick_o` is 0.
- R2: While running, `chip_tick_o` is high in a cycle exactly when the phase accumulator plus 341 reaches 1915 or more, and the accumulator then wraps by subtracting 1915. Any 5745 consecutive running cycles contain exactly 1023 ticks, and two ticks are never adjacent.
- R3: The start value sets the first tick. With a start value of 766 (0.4 chip), the first tick comes in the 4th cycle after the start edge. With 0, it comes in the 6th.
- R4: Mask bit 0 selects the last register stage and bit 9 selects the first. The mask 10'b0000000001 gives the undelayed sequence. G1 feedback uses the coefficient vector 0010000001 and G2 uses 0110010111, where the leftmost digit belongs to stage 1.
- R5: Bit i of `code_o` equals parity(G1 & M1[i]) XOR parity(G2 & M2[i]). The registers change only on a tick or a start.
- R6: With M1 = 10'b0000000001 and M2 = 10'b0100010000, the first ten chips after start are 1,1,0,0,1,0,0,0,0,0.
- R7: All four replicas run at the same time from the shared registers, and each one follows its own mask pair.
- R8: Masks and the start value are captured only on `start_i`. Changes to them while running have no effect until the next start.
- R9: On the 1023rd tick after a seed, both registers are reseeded to all ones. The output pattern repeats every 5745 cycles.
- R10: A start while running restarts the accumulator, the registers and the chip count from the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start/restart pulse |
| frac_init_i | input | 11 | Accumulator start value, below 1915 |
| g1_mask_i | input | 40 | Four G1 masks, replica i at bits [10i+9:10i] |
| g2_mask_i | input | 40 | Four G2 masks, replica i at bits [10i+9:10i] |
| code_o | output | 4 | One code bit per replica |
| chip_tick_o | output | 1 | Chip advance in this cycle |
| busy_o | output | 1 | High in ST_RUN |

## Verification
The hardest condition to reach is the period boundary. The 1023rd chip and its reseed only arrive after 5745 uninterrupted running cycles. The bench runs long enough to compare one full period with the next, and a behavioural sequence table catches any early or late reseed on every clock. The mask-capture rule is covered by changing the mask and start-value inputs mid-run, and the restart rule by issuing a second start while still in ST_RUN.

// File: rtl/ca_pkg.sv
package ca_pkg;
    localparam int          CA_W    = 10;
    localparam logic [9:0]  G1_POLY = 10'b0010000001;
    localparam logic [9:0]  G2_POLY = 10'b0110010111;
    localparam logic [9:0]  CA_SEED = 10'b1111111111;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ca_state_e;
endpackage

// File: rtl/ca_chip_timer.sv
module ca_chip_timer #(
    parameter int MOD   = 1915,
    parameter int STEP  = 341,
    parameter int ACC_W = $clog2(MOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [ACC_W-1:0] init_i,
    output logic             tick_o,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W:0] MOD_V  = (ACC_W+1)'(MOD);
    localparam logic [ACC_W:0] STEP_V = (ACC_W+1)'(STEP);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             wrap;

    assign sum    = {1'b0, acc_q} + STEP_V;
    assign wrap   = (sum >= MOD_V);
    assign tick_o = run_i & ~load_i & wrap;
    assign acc_o  = acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= init_i;
        end else if (run_i) begin
            if (wrap) acc_q <= ACC_W'(sum - MOD_V);
            else      acc_q <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ca_lfsr.sv
module ca_lfsr #(
    parameter int                W    = ca_pkg::CA_W,
    parameter logic [W-1:0]      POLY = ca_pkg::G1_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] st_q;
    logic         fb;

    assign fb      = ^(st_q & POLY);
    assign state_o = st_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '1;
        else if (load_i) st_q <= '1;
        else if (step_i) st_q <= {fb, st_q[W-1:1]};
    end
endmodule

// File: rtl/ca_tap.sv
module ca_tap #(
    parameter int W = ca_pkg::CA_W
) (
    input  logic [W-1:0] g1_i,
    input  logic [W-1:0] g2_i,
    input  logic [W-1:0] m1_i,
    input  logic [W-1:0] m2_i,
    output logic         bit_o
);
    assign bit_o = (^(g1_i & m1_i)) ^ (^(g2_i & m2_i));
endmodule

// File: rtl/ca_code_gen.sv
module ca_code_gen #(
    parameter int NREP  = 4,
    parameter int MOD   = 1915,
    parameter int STEP  = 341,
    parameter int CHIPS = 1023
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [$clog2(MOD)-1:0]        frac_init_i,
    input  logic [NREP*ca_pkg::CA_W-1:0]  g1_mask_i,
    input  logic [NREP*ca_pkg::CA_W-1:0]  g2_mask_i,
    output logic [NREP-1:0]               code_o,
    output logic                          chip_tick_o,
    output logic                          busy_o
);
    import ca_pkg::*;

    localparam int MW    = CA_W;
    localparam int ACC_W = $clog2(MOD);
    localparam int CNT_W = $clog2(CHIPS);

    ca_state_e             state_q, state_d;
    logic [NREP*MW-1:0]    m1_q, m2_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [ACC_W-1:0]      acc_q;
    logic [MW-1:0]         g1_st, g2_st;
    logic                  tick;
    logic                  period_end;
    logic                  running;
    logic [NREP-1:0]       tap_bits;

    assign running    = (state_q == ST_RUN);
    assign period_end = tick && (cnt_q == CNT_W'(CHIPS-1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // capture masks and chip counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1_q  <= '0;
            m2_q  <= '0;
            cnt_q <= '0;
        end else if (start_i) begin
            m1_q  <= g1_mask_i;
            m2_q  <= g2_mask_i;
            cnt_q <= '0;
        end else if (period_end) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    ca_chip_timer #(.MOD(MOD), .STEP(STEP), .ACC_W(ACC_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .run_i  (running),
        .init_i (frac_init_i),
        .tick_o (tick),
        .acc_o  (acc_q)
    );

    ca_lfsr #(.W(MW), .POLY(G1_POLY)) u_g1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i | period_end),
        .step_i  (tick),
        .state_o (g1_st)
    );

    ca_lfsr #(.W(MW), .POLY(G2_POLY)) u_g2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i | period_end),
        .step_i  (tick),
        .state_o (g2_st)
    );

    for (genvar i = 0; i < NREP; i++) begin : g_rep
        ca_tap #(.W(MW)) u_tap (
            .g1_i  (g1_st),
            .g2_i  (g2_st),
            .m1_i  (m1_q[i*MW +: MW]),
            .m2_i  (m2_q[i*MW +: MW]),
            .bit_o (tap_bits[i])
        );
    end

    // outputs
    always_comb begin
        code_o      = '0;
        chip_tick_o = 1'b0;
        busy_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                code_o      = tap_bits;
                chip_tick_o = tick;
                busy_o      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ca_code_gen_chk.sv
module ca_code_gen_chk #(
    parameter int NREP  = 4,
    parameter int MOD   = 1915,
    parameter int CHIPS = 1023,
    parameter int ACC_W = 11,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [ACC_W-1:0] frac_init_i,
    input logic [NREP-1:0]  code_o,
    input logic             chip_tick_o,
    input logic             busy_o,
    input logic [ACC_W-1:0] acc_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [9:0]       g1_st,
    input logic [9:0]       g2_st
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (code_o == '0) && !chip_tick_o);

    p_tick_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_tick_o |=> !chip_tick_o);

    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(MOD));

    p_start_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (g1_st == 10'h3FF) && (g2_st == 10'h3FF) && (acc_q == $past(frac_init_i)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i && !chip_tick_o) |=> $stable(g1_st) && $stable(g2_st));

    p_wrap_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_tick_o && !start_i && cnt_q == CNT_W'(CHIPS-1)) |=> (g1_st == 10'h3FF) && (g2_st == 10'h3FF));

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

bind ca_code_gen ca_code_gen_chk #(
    .NREP(NREP), .MOD(MOD), .CHIPS(CHIPS), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .frac_init_i (frac_init_i),
    .code_o      (code_o),
    .chip_tick_o (chip_tick_o),
    .busy_o      (busy_o),
    .acc_q       (acc_q),
    .cnt_q       (cnt_q),
    .g1_st       (g1_st),
    .g2_st       (g2_st)
);

// File: tb/tb_ca_code_gen.sv
module tb_ca_code_gen;
    localparam int NREP = 4;
    localparam int PER  = 5745;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [10:0]       frac_init_i = '0;
    logic [NREP*10-1:0] g1_mask_i = '0;
    logic [NREP*10-1:0] g2_mask_i = '0;
    logic [NREP-1:0]   code_o;
    logic              chip_tick_o;
    logic              busy_o;

    ca_code_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frac_init_i(frac_init_i),
        .g1_mask_i(g1_mask_i), .g2_mask_i(g2_mask_i),
        .code_o(code_o), .chip_tick_o(chip_tick_o), .busy_o(busy_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1";

    // reference sequences from the recurrences of both polynomials
    bit s1 [0:1032];
    bit s2 [0:1032];

    int         m_acc = 0;
    int         m_chip = 0;
    bit         m_run = 0;
    logic [9:0] mm1 [NREP];
    logic [9:0] mm2 [NREP];

    function automatic bit seq_tap(input int which, input logic [9:0] m, input int c);
        bit r = 0;
        for (int k = 1; k <= 10; k++)
            if (m[10-k]) r ^= (which == 1) ? s1[c+10-k] : s2[c+10-k];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int n = 0; n < 10; n++) begin s1[n] = 1; s2[n] = 1; end
        for (int n = 0; n < 1023; n++) begin
            s1[n+10] = s1[n+7] ^ s1[n];
            s2[n+10] = s2[n+8] ^ s2[n+7] ^ s2[n+4] ^ s2[n+2] ^ s2[n+1] ^ s2[n];
        end
        for (int i = 0; i < NREP; i++) begin mm1[i] = '0; mm2[i] = '0; end
    end

    // behavioural model, advanced at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_acc = 0; m_chip = 0;
        end else if (start_i) begin
            m_run = 1; m_acc = int'(frac_init_i); m_chip = 0;
            for (int i = 0; i < NREP; i++) begin
                mm1[i] = g1_mask_i[i*10 +: 10];
                mm2[i] = g2_mask_i[i*10 +: 10];
            end
        end else if (m_run) begin
            m_acc += 341;
            if (m_acc >= 1915) begin
                m_acc -= 1915;
                m_chip = (m_chip + 1) % 1023;
            end
        end
    end

    // compare every cycle away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NREP-1:0] exp_code;
            bit exp_tick;
            exp_code = '0;
            for (int i = 0; i < NREP; i++)
                if (m_run) exp_code[i] = seq_tap(1, mm1[i], m_chip) ^ seq_tap(2, mm2[i], m_chip);
            exp_tick = m_run && !start_i && (m_acc + 341 >= 1915);
            check({phase, " R5 R7 code"}, 32'(code_o), 32'(exp_code));
            check({phase, " R2 tick"}, 32'(chip_tick_o), 32'(exp_tick));
            check({phase, " busy"}, 32'(busy_o), 32'(m_run));
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            finish_run();
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic first_tick(input string req, input int exp_n);
        int n = 0;
        for (int k = 1; k <= 10 && n == 0; k++) begin
            @(negedge clk);
            if (chip_tick_o) n = k;
        end
        check(req, 32'(n), 32'(exp_n));
    endtask

    logic [NREP-1:0] rec [PER];

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: quiet after reset
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 idle code", 32'(code_o), 32'h0);
            check("R1 idle tick", 32'(chip_tick_o), 32'h0);
            check("R1 idle busy", 32'(busy_o), 32'h0);
        end

        // R4 R6 R7: replica 0 = undelayed G1 with PRN-1 G2 taps; others differ
        phase = "R4";
        g1_mask_i = {10'b1010010011, 10'b1000000000, 10'b0000000010, 10'b0000000001};
        g2_mask_i = {10'b0111000101, 10'b0000000001, 10'b0010001000, 10'b0100010000};
        frac_init_i = 11'd766;
        pulse_start();
        // R3: 0.4-chip start value -> first tick on 4th cycle
        first_tick("R3 first tick with 766", 4);

        // R6: first ten chips of replica 0 (restart to sample from chip 0)
        begin
            logic [9:0] got;
            phase = "R6";
            pulse_start();
            @(negedge clk);
            got[9] = code_o[0];
            for (int c = 8; c >= 0; c--) begin
                do @(negedge clk); while (!chip_tick_o);
                @(negedge clk);
                got[c] = code_o[0];
            end
            check("R6 first ten chips", 32'(got), 32'(10'b1100100000));
        end

        // R2: tick count over one period
        begin
            int nt = 0;
            phase = "R2";
            for (int k = 0; k < PER; k++) begin
                @(negedge clk);
                if (chip_tick_o) nt++;
                rec[k] = code_o;
            end
            check("R2 ticks per 5745 cycles", 32'(nt), 32'd1023);
        end

        // R9: next period repeats the previous one
        begin
            int mism = 0;
            phase = "R9";
            for (int k = 0; k < PER; k++) begin
                @(negedge clk);
                if (code_o !== rec[k]) mism++;
            end
            check("R9 period repeat mismatches", 32'(mism), 32'd0);
        end

        // R8: new inputs without start are ignored (model keeps latched values)
        phase = "R8";
        @(posedge clk); #1;
        g1_mask_i = {10'b0000000001, 10'b0000000001, 10'b0000000001, 10'b0000000001};
        g2_mask_i = {10'b1000000000, 10'b0100000000, 10'b0000100000, 10'b0000000001};
        frac_init_i = 11'd0;
        repeat (2000) @(posedge clk);

        // R10: restart while running with start value 0 -> first tick on 6th cycle
        phase = "R10";
        pulse_start();
        first_tick("R10 restart first tick with 0", 6);
        repeat (3000) @(posedge clk);

        @(negedge clk);
        finish_run();
    end
endmodule